// File: doc/BRIEF.md
# Serial Command Port for an Eight-Channel Driver Controller

This block is the serial slave front end of an output-driver controller. A host selects it by pulling the active-low chip select low. It then clocks in a 16-bit command word on the data input, and on the same clocks it shifts out a word that reports which drivers have a fault. The fault flags are copied into the shift register at the moment chip select falls. The received command changes the driver enables only when chip select rises again, and only if the frame held exactly sixteen serial clocks.

The serial clock, chip select and data input are brought into the faster system clock domain through two-flop synchronisers. All edge detection is done in that domain. The serial output comes with a separate output-enable, so that a pad cell can place the line in high impedance between frames. An enable input puts the block to sleep: all driver enables are forced off and serial traffic is not acted on. The bits shifted out after the first sixteen are the input bits delayed by sixteen clocks, so several such ports can be chained on one chip select.

Top module: `drvctl_spi_cmd`

## Requirements
- R1: After reset, every driver enable is 0 and the serial output-enable is 0.
- R2: While chip select is high, the serial output-enable is 0. Serial clock and data-input activity with chip select high has no effect on the driver enables.
- R3: A falling chip select with the block awake raises the serial output-enable and captures the fault word. The fault word has bit i equal to the fault flag of driver i+1 (1 = faulted, 0 = normal) in bits 7..0, and zeros in bits 15..8. Fault changes after the capture do not alter the word that is shifted out.
- R4: The data input is sampled on each rising serial clock edge, most significant bit first. The first bit received becomes command bit 15.
- R5: The serial output changes only after a falling serial clock edge. It holds its value from before a rising edge until the next falling edge. The first bit shown is fault-word bit 15.
- R6: The driver enables change only when chip select rises. They then take command bits 7..0, with bit i driving driver i+1. Command bits 15..8 have no effect.
- R7: A frame with fewer or more than 16 rising serial clock edges is discarded, and the driver enables keep their previous value.
- R8: In a frame longer than 16 bits, the output bits from position 17 on repeat the data-input bits from the start of the frame, delayed by 16 clocks.
- R9: While the enable input is low, all driver enables are 0, the serial output-enable is 0 and frames are not committed. After the enable input returns high, the next valid frame commits normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Awake when high, sleep when low |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| csn_i | input | 1 | Active-low chip select |
| si_i | input | 1 | Serial data input |
| so_o | output | 1 | Serial data output |
| so_oe_o | output | 1 | Output-enable for the serial output pad |
| fault_i | input | 8 | Per-driver fault flags, 1 = faulted |
| drv_en_o | output | 8 | Per-driver enable outputs |

## Verification
The checker watches four properties on every cycle:
- the driver enables move only right after chip select has risen, or because of sleep;
- the output-enable rises only with chip select low and the block awake;
- sleep clears both the enables and the output-enable;
- the serial output never changes while the serial clock is high.

Directed scenarios are needed for the rest. These cover the bit order of the command and of the fault word, the snapshot holding while fault flags change mid-frame, and short and long frames being discarded. They also cover the sixteen-clock pass-through in a long frame, and recovery from sleep.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;

  // Edge events derived in the system clock domain
  typedef struct packed {
    logic cs_fall;
    logic cs_rise;
    logic sclk_rise;
    logic sclk_fall;
  } spi_evt_t;

  localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/drvctl_sync.sv
module drvctl_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/drvctl_edge.sv
module drvctl_edge
  import drvctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_n_s,
  input  logic     sclk_s,
  output spi_evt_t evt_o
);

  logic cs_prev_q, sclk_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_n_s;
      sclk_prev_q <= sclk_s;
    end
  end

  always_comb begin
    evt_o.cs_fall   = cs_prev_q & ~cs_n_s;
    evt_o.cs_rise   = ~cs_prev_q & cs_n_s;
    // serial clock edges only count while selected
    evt_o.sclk_rise = ~cs_n_s & sclk_s & ~sclk_prev_q;
    evt_o.sclk_fall = ~cs_n_s & ~sclk_s & sclk_prev_q;
  end

endmodule

// File: rtl/drvctl_shift.sv
module drvctl_shift
  import drvctl_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned NUM_DRV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  spi_evt_t           evt_i,
  input  logic               si_s,
  input  logic [NUM_DRV-1:0] fault_i,
  output logic               so_o,
  output logic               so_oe_o,
  output logic               commit_o,
  output logic [NUM_DRV-1:0] cmd_o
);

  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sr_q, sr_d;
  logic              smp_q, smp_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              act_q, act_d;
  logic [WORD_W-1:0] status_w;

  // status word: fault flags in the low bits, zero padding above
  for (genvar b = 0; b < WORD_W; b++) begin : g_status
    if (b < NUM_DRV) begin : g_flag
      assign status_w[b] = fault_i[b];
    end else begin : g_pad
      assign status_w[b] = 1'b0;
    end
  end

  always_comb begin
    sr_d  = sr_q;
    smp_d = smp_q;
    cnt_d = cnt_q;
    act_d = act_q;
    if (!en_i) begin
      act_d = 1'b0;
    end else if (evt_i.cs_fall) begin
      act_d = 1'b1;
      sr_d  = status_w;
      cnt_d = '0;
    end else if (act_q) begin
      if (evt_i.cs_rise) begin
        act_d = 1'b0;
      end else begin
        if (evt_i.sclk_rise) begin
          smp_d = si_s;
          if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
        end
        if (evt_i.sclk_fall) begin
          sr_d = {sr_q[WORD_W-2:0], smp_q};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      smp_q <= 1'b0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      smp_q <= smp_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign so_o     = sr_q[WORD_W-1] & act_q;
  assign so_oe_o  = act_q;
  assign commit_o = act_q & en_i & evt_i.cs_rise & (cnt_q == CNT_FULL);
  assign cmd_o    = sr_q[NUM_DRV-1:0];

endmodule

// File: rtl/drvctl_cmd_reg.sv
module drvctl_cmd_reg #(
  parameter int unsigned NUM_DRV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               commit_i,
  input  logic [NUM_DRV-1:0] cmd_i,
  output logic [NUM_DRV-1:0] drv_en_o
);

  logic [NUM_DRV-1:0] en_q, en_d;
  logic               load;

  always_comb begin
    load = 1'b0;
    en_d = en_q;
    if (!en_i) begin
      load = 1'b1;
      en_d = '0;
    end else if (commit_i) begin
      load = 1'b1;
      en_d = cmd_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (load) en_q <= en_d;
  end

  assign drv_en_o = en_q;

endmodule

// File: rtl/drvctl_spi_cmd.sv
module drvctl_spi_cmd
  import drvctl_pkg::*;
#(
  parameter int unsigned WORD_W     = 16,
  parameter int unsigned NUM_DRV    = 8,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               csn_i,
  input  logic               si_i,
  output logic               so_o,
  output logic               so_oe_o,
  input  logic [NUM_DRV-1:0] fault_i,
  output logic [NUM_DRV-1:0] drv_en_o
);

  localparam int unsigned N_SYNC = 3;

  logic              rst_meta_q, rst_int_n;
  logic [N_SYNC-1:0] raw_in, syn_out;
  spi_evt_t          evt;
  logic              commit;
  logic [NUM_DRV-1:0] cmd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  assign raw_in = {csn_i, sclk_i, si_i};

  drvctl_sync #(
    .WIDTH  (N_SYNC),
    .STAGES (SYNC_DEPTH),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_int_n),
    .d_i  (raw_in),
    .q_o  (syn_out)
  );

  drvctl_edge edge_i (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cs_n_s(syn_out[2]),
    .sclk_s(syn_out[1]),
    .evt_o (evt)
  );

  drvctl_shift #(
    .WORD_W (WORD_W),
    .NUM_DRV(NUM_DRV)
  ) shift_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (en_i),
    .evt_i   (evt),
    .si_s    (syn_out[0]),
    .fault_i (fault_i),
    .so_o    (so_o),
    .so_oe_o (so_oe_o),
    .commit_o(commit),
    .cmd_o   (cmd)
  );

  drvctl_cmd_reg #(
    .NUM_DRV(NUM_DRV)
  ) cmd_i (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en_i    (en_i),
    .commit_i(commit),
    .cmd_i   (cmd),
    .drv_en_o(drv_en_o)
  );

endmodule

// File: rtl/drvctl_spi_cmd_chk.sv
module drvctl_spi_cmd_chk #(
  parameter int unsigned NUM_DRV = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic               sclk_i,
  input logic               csn_i,
  input logic               so_o,
  input logic               so_oe_o,
  input logic [NUM_DRV-1:0] drv_en_o
);

  // R6: awake enables move only once chip select is back high
  p_commit_on_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_i) && (drv_en_o != $past(drv_en_o))) |-> $past(csn_i));

  // R2 / R3: output driver turns on only while selected and awake
  p_oe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe_o) |-> (!$past(csn_i) && $past(en_i)));

  // R9: sleep clears enables and output driver
  p_sleep_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ((drv_en_o == '0) && !so_oe_o));

  // R5: data out never moves while the serial clock is high
  p_so_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> !$past(sclk_i));

endmodule

bind drvctl_spi_cmd drvctl_spi_cmd_chk #(.NUM_DRV(NUM_DRV)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (en_i),
  .sclk_i  (sclk_i),
  .csn_i   (csn_i),
  .so_o    (so_o),
  .so_oe_o (so_oe_o),
  .drv_en_o(drv_en_o)
);

// File: tb/drvctl_spi_cmd_tb_top.sv
module drvctl_spi_cmd_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n, en, sclk, csn, si;
  logic       so, so_oe;
  logic [7:0] fault, drv_en;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  drvctl_spi_cmd dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .sclk_i  (sclk),
    .csn_i   (csn),
    .si_i    (si),
    .so_o    (so),
    .so_oe_o (so_oe),
    .fault_i (fault),
    .drv_en_o(drv_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nb, input logic [31:0] tx, input logic [7:0] f0,
                       input logic [7:0] f1, output logic [31:0] rx, output int glitch,
                       output logic oe_in, output logic [7:0] drv_mid);
    logic smp;
    fault = f0;
    wclk(2);
    csn = 1'b0;
    wclk(HALF);
    rx = '0;
    glitch = 0;
    oe_in = so_oe;
    for (int i = 0; i < nb; i++) begin
      si = tx[nb-1-i];
      if (i == 1) fault = f1;
      wclk(HALF);
      smp = so;
      rx = {rx[30:0], smp};
      sclk = 1'b1;
      wclk(HALF);
      if (so !== smp) glitch++;
      sclk = 1'b0;
    end
    wclk(HALF);
    drv_mid = drv_en;
    csn = 1'b1;
    wclk(HALF);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 drv_en after reset", 32'(drv_en), 32'h0);
    chk("R1 so_oe after reset", 32'(so_oe), 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    frame(16, 32'h3C5A, 8'hA5, 8'hA5, rx, g, oe_in, mid);
    chk("R3 oe during frame", 32'(oe_in), 32'h1);
    chk("R3 status word msb first", rx & 32'hFFFF, 32'h00A5);
    chk("R5 so stable across rise", 32'(g), 32'h0);
    chk("R6 enables unchanged before cs rise", 32'(mid), 32'h00);
    chk("R4 R6 commit low byte", 32'(drv_en), 32'h5A);
    chk("R2 oe off after frame", 32'(so_oe), 32'h0);
  endtask

  task automatic t_order;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    frame(16, 32'hFF81, 8'h01, 8'h01, rx, g, oe_in, mid);
    chk("R4 bit order commit", 32'(drv_en), 32'h81);
    chk("R3 driver1 in bit0", rx & 32'hFFFF, 32'h0001);
    chk("R6 mid frame hold", 32'(mid), 32'h5A);
  endtask

  task automatic t_snapshot;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    frame(16, 32'h0033, 8'h0F, 8'hF0, rx, g, oe_in, mid);
    chk("R3 snapshot ignores later faults", rx & 32'hFFFF, 32'h000F);
    chk("R6 commit after snapshot frame", 32'(drv_en), 32'h33);
  endtask

  task automatic t_idle;
    int oe_seen = 0;
    csn = 1'b1;
    for (int i = 0; i < 20; i++) begin
      si = i[0];
      sclk = 1'b1; wclk(HALF);
      if (so_oe) oe_seen++;
      sclk = 1'b0; wclk(HALF);
      if (so_oe) oe_seen++;
    end
    chk("R2 oe stays off while deselected", 32'(oe_seen), 32'h0);
    chk("R2 deselected clocks ignored", 32'(drv_en), 32'h33);
  endtask

  task automatic t_bad_len;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    frame(15, 32'h7FFF, 8'h00, 8'h00, rx, g, oe_in, mid);
    chk("R7 short frame discarded", 32'(drv_en), 32'h33);
    frame(17, 32'h1FFFF, 8'h00, 8'h00, rx, g, oe_in, mid);
    chk("R7 long frame discarded", 32'(drv_en), 32'h33);
  endtask

  task automatic t_daisy;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    frame(32, 32'hBEEF1234, 8'h42, 8'h42, rx, g, oe_in, mid);
    chk("R8 status first half", rx >> 16, 32'h0042);
    chk("R8 pass-through delayed 16", rx & 32'hFFFF, 32'hBEEF);
    chk("R7 32-bit frame discarded", 32'(drv_en), 32'h33);
  endtask

  task automatic t_sleep;
    logic [31:0] rx; int g; logic oe_in; logic [7:0] mid;
    en = 1'b0;
    wclk(3);
    chk("R9 sleep clears enables", 32'(drv_en), 32'h0);
    frame(16, 32'h00FF, 8'h11, 8'h11, rx, g, oe_in, mid);
    chk("R9 no output drive asleep", 32'(oe_in), 32'h0);
    chk("R9 no commit asleep", 32'(drv_en), 32'h0);
    en = 1'b1;
    wclk(3);
    frame(16, 32'h0096, 8'h11, 8'h11, rx, g, oe_in, mid);
    chk("R9 commit after wake", 32'(drv_en), 32'h96);
    chk("R9 status after wake", rx & 32'hFFFF, 32'h0011);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; sclk = 1'b0; csn = 1'b1; si = 1'b0; fault = '0;
    t_reset();
    t_basic();
    t_order();
    t_snapshot();
    t_idle();
    t_bad_len();
    t_daisy();
    t_sleep();
    t_reset();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule